// File: doc/BRIEF.md
# Double-Buffered DAC Code Bank

This block holds the digital codes for a group of converter channels, between the word assembler of a serial front end and the converter cores. Each channel has two stages. A staging register takes codes from the write port. An output register drives the converter. The front end presents a complete 16-bit word on the write port together with a channel select and a hold bit. The block files the word into the staging register of the selected channel, or of every channel when the select carries the broadcast value.

A write with the hold bit low is a commit. In the clock edge that accepts it, every channel whose staging register was written since the previous commit copies its staging content into its output register. The channel written by the commit itself takes part with its new value. Channels that were not touched are left alone and raise no update strobe. This lets software preload several channels and switch them together without disturbing the others.

The two top bits of each word select an output termination mode. The mode is staged like a code and is applied to the channel's mode output at that channel's next transfer. A word that requests a power-down mode leaves the channel's code untouched, so the previous code returns when the channel is brought back to normal operation.

Top module: `dac_dbuf_bank`

## Requirements
- R1: A synchronous active-high reset clears every output code to zero, sets every mode output to 00 (normal), drops all update strobes and clears all staging registers and pending marks, so a commit made just after reset updates only the channel it writes.
- R2: An accepted write with `wr_hold` high changes only staging state; `dac_code`, `pd_mode` and `upd_strobe` stay as they were.
- R3: An accepted write with `wr_hold` low commits every pending channel, including the channel written by that same word (with its new value), and the new codes and modes appear at the outputs on the clock edge that accepts the write.
- R4: A channel not written since the previous commit keeps its output code and mode through a commit.
- R5: `upd_strobe[i]` is high for exactly the one cycle after a commit transfers channel i, and `dac_code`/`pd_mode` of a channel change only together with its strobe.
- R6: Several writes to the same channel before a commit leave the last written code in its output register.
- R7: Select value 2^SEL_W-1 (all ones) is a broadcast that writes the word into every channel's staging register and marks them all pending.
- R8: A write whose select is neither a channel index below NUM_CH nor the broadcast value is ignored entirely: nothing is staged and it is not a commit.
- R9: Word bits [15:14] are the mode field: 00 normal, 01 power-down with 1 kOhm pull-down, 10 power-down with 100 kOhm pull-down, 11 power-down with floating output; it reaches `pd_mode` for that channel at its next transfer.
- R10: A write with a nonzero mode field stages only the mode; the channel's code (word bits [CODE_W-1:0] for a normal write) is retained, so a later normal-mode write restores operation with whatever code that word carries.
- R11: With `wr_valid` low, no input has any effect on outputs or staging state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | A complete word is present on the write port this cycle |
| wr_word | input | 16 | Mode field in [15:14], code in [CODE_W-1:0] |
| wr_sel | input | SEL_W | Channel index, or all ones for broadcast |
| wr_hold | input | 1 | 1: stage only; 0: commit all pending channels |
| dac_code | output | NUM_CH*CODE_W | Output codes, channel i in bits [CODE_W*i +: CODE_W] |
| pd_mode | output | NUM_CH*2 | Mode per channel, channel i in bits [2*i +: 2] |
| upd_strobe | output | NUM_CH | One-cycle pulse per channel on each transfer |

## Verification
Staging and committing coincide whenever a commit word also carries a new code, because that channel must be written and transferred in the same edge and must not hand the stale staging value to the converter. The bench stages two channels with the hold bit set and then sends the commit to a third channel. It expects all three new codes, and a strobe pattern covering exactly those three, one cycle after the commit. The same pairing is then driven with a power-down word as the commit, and the bench checks that the mode changes while the code stays.

// File: rtl/dac_bank_pkg.sv
package dac_bank_pkg;

    localparam int WORD_W   = 16;
    localparam int MODE_MSB = 15;
    localparam int MODE_LSB = 14;

    typedef enum logic [1:0] {
        PDM_ACTIVE    = 2'b00,
        PDM_PULL_1K   = 2'b01,
        PDM_PULL_100K = 2'b10,
        PDM_FLOAT     = 2'b11
    } pd_mode_e;

    function automatic pd_mode_e word_mode(input logic [WORD_W-1:0] w);
        return pd_mode_e'(w[MODE_MSB:MODE_LSB]);
    endfunction

endpackage

// File: rtl/dac_sel_decode.sv
module dac_sel_decode #(
    parameter int NUM_CH = 4,
    parameter int SEL_W  = 3
) (
    input  logic             valid,
    input  logic [SEL_W-1:0] sel,
    output logic [NUM_CH-1:0] wen,
    output logic             sel_ok
);
    localparam logic [SEL_W-1:0] BCAST = '1;

    logic bcast;
    assign bcast = (sel == BCAST);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
        assign wen[i] = valid && ((sel == SEL_W'(i)) || bcast);
    end

    assign sel_ok = bcast || (32'(sel) < NUM_CH);
endmodule

// File: rtl/dac_chan_slice.sv
module dac_chan_slice
    import dac_bank_pkg::*;
#(
    parameter int CODE_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wen,
    input  logic [CODE_W-1:0] new_code,
    input  pd_mode_e          new_mode,
    input  logic              commit,
    output logic [CODE_W-1:0] out_code,
    output pd_mode_e          out_mode,
    output logic              strobe
);
    typedef struct packed {
        logic [CODE_W-1:0] code;
        pd_mode_e          mode;
    } stage_t;

    stage_t stg_q, stg_n, out_q;
    logic   pend_q, pend_n;

    always_comb begin
        stg_n = stg_q;
        if (wen) begin
            stg_n.mode = new_mode;
            if (new_mode == PDM_ACTIVE) stg_n.code = new_code;
        end
        pend_n = pend_q | wen;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_q  <= '{code: '0, mode: PDM_ACTIVE};
            out_q  <= '{code: '0, mode: PDM_ACTIVE};
            pend_q <= 1'b0;
            strobe <= 1'b0;
        end else begin
            stg_q <= stg_n;
            if (commit && pend_n) begin
                out_q  <= stg_n;
                pend_q <= 1'b0;
                strobe <= 1'b1;
            end else begin
                pend_q <= pend_n;
                strobe <= 1'b0;
            end
        end
    end

    assign out_code = out_q.code;
    assign out_mode = out_q.mode;
endmodule

// File: rtl/dac_dbuf_bank.sv
module dac_dbuf_bank
    import dac_bank_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CODE_W = 14,
    parameter int SEL_W  = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_valid,
    input  logic [WORD_W-1:0]        wr_word,
    input  logic [SEL_W-1:0]         wr_sel,
    input  logic                     wr_hold,
    output logic [NUM_CH*CODE_W-1:0] dac_code,
    output logic [NUM_CH*2-1:0]      pd_mode,
    output logic [NUM_CH-1:0]        upd_strobe
);
    localparam int PAD_W = MODE_LSB - CODE_W;

    logic [NUM_CH-1:0] wen;
    logic              sel_ok;
    logic              commit;
    pd_mode_e          new_mode;
    logic [CODE_W-1:0] new_code;
    logic [PAD_W-1:0]  pad_bits;

    assign new_mode = word_mode(wr_word);
    assign {pad_bits, new_code} = wr_word[MODE_LSB-1:0];

    dac_sel_decode #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_dec (
        .valid  (wr_valid),
        .sel    (wr_sel),
        .wen    (wen),
        .sel_ok (sel_ok)
    );

    assign commit = wr_valid && sel_ok && !wr_hold;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        pd_mode_e m;
        dac_chan_slice #(.CODE_W(CODE_W)) u_slice (
            .clk      (clk),
            .rst      (rst),
            .wen      (wen[i]),
            .new_code (new_code),
            .new_mode (new_mode),
            .commit   (commit),
            .out_code (dac_code[CODE_W*i +: CODE_W]),
            .out_mode (m),
            .strobe   (upd_strobe[i])
        );
        assign pd_mode[2*i +: 2] = m;
    end

    logic unused_ok;
    assign unused_ok = ^pad_bits;
endmodule

// File: rtl/dac_dbuf_bank_chk.sv
module dac_dbuf_bank_chk #(
    parameter int NUM_CH = 4,
    parameter int CODE_W = 14
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     wr_valid,
    input logic                     wr_hold,
    input logic [NUM_CH*CODE_W-1:0] dac_code,
    input logic [NUM_CH*2-1:0]      pd_mode,
    input logic [NUM_CH-1:0]        upd_strobe
);
    a_r2_hold_keeps_outputs: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_hold) |=> ($stable(dac_code) && $stable(pd_mode) && upd_strobe == '0));

    a_r11_idle_no_update: assert property (@(posedge clk) disable iff (rst)
        !wr_valid |=> ($stable(dac_code) && $stable(pd_mode) && upd_strobe == '0));

    a_r5_strobe_needs_commit: assert property (@(posedge clk) disable iff (rst)
        (upd_strobe != '0) |-> $past(wr_valid && !wr_hold));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        a_r5_change_has_strobe: assert property (@(posedge clk) disable iff (rst)
            (!$stable(dac_code[CODE_W*i +: CODE_W]) || !$stable(pd_mode[2*i +: 2]))
            |-> upd_strobe[i]);
    end
endmodule

bind dac_dbuf_bank dac_dbuf_bank_chk #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_valid   (wr_valid),
    .wr_hold    (wr_hold),
    .dac_code   (dac_code),
    .pd_mode    (pd_mode),
    .upd_strobe (upd_strobe)
);

// File: tb/dac_dbuf_bank_bench.sv
module dac_dbuf_bank_bench;
    localparam int NUM_CH = 4;
    localparam int CODE_W = 14;
    localparam int SEL_W  = 3;

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic                     wr_valid = 1'b0;
    logic [15:0]              wr_word = '0;
    logic [SEL_W-1:0]         wr_sel = '0;
    logic                     wr_hold = 1'b1;
    logic [NUM_CH*CODE_W-1:0] dac_code;
    logic [NUM_CH*2-1:0]      pd_mode;
    logic [NUM_CH-1:0]        upd_strobe;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    dac_dbuf_bank #(.NUM_CH(NUM_CH), .CODE_W(CODE_W), .SEL_W(SEL_W)) u_dac_dbuf_bank (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_word(wr_word),
        .wr_sel(wr_sel), .wr_hold(wr_hold), .dac_code(dac_code),
        .pd_mode(pd_mode), .upd_strobe(upd_strobe)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic chk_ch(input string tag, input int ch, input logic [CODE_W-1:0] code,
                          input logic [1:0] mode);
        chk({tag, " code"}, 32'(dac_code[CODE_W*ch +: CODE_W]), 32'(code));
        chk({tag, " mode"}, 32'(pd_mode[2*ch +: 2]), 32'(mode));
    endtask

    // drives one word for one cycle; returns at the negedge after the accepting edge
    task automatic put(input logic [SEL_W-1:0] sel, input logic [1:0] mode,
                       input logic [CODE_W-1:0] code, input logic hold);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_sel   = sel;
        wr_word  = {mode, code};
        wr_hold  = hold;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset;
        do_reset();
        for (int c = 0; c < NUM_CH; c++) chk_ch("R1 reset", c, '0, 2'b00);
        chk("R1 reset strobe", 32'(upd_strobe), 32'h0);
    endtask

    task automatic t_stage_then_commit;
        put(3'd0, 2'b00, 14'h0123, 1'b1);
        chk_ch("R2 hold ch0", 0, '0, 2'b00);
        chk("R2 hold strobe", 32'(upd_strobe), 32'h0);
        put(3'd2, 2'b00, 14'h0456, 1'b1);
        chk_ch("R2 hold ch2", 2, '0, 2'b00);
        put(3'd1, 2'b00, 14'h0789, 1'b0);
        chk_ch("R3 commit ch0", 0, 14'h0123, 2'b00);
        chk_ch("R3 commit ch1 same word", 1, 14'h0789, 2'b00);
        chk_ch("R3 commit ch2", 2, 14'h0456, 2'b00);
        chk_ch("R4 untouched ch3", 3, '0, 2'b00);
        chk("R5 strobe set", 32'(upd_strobe), 32'b0111);
        @(negedge clk);
        chk("R5 strobe one cycle", 32'(upd_strobe), 32'h0);
    endtask

    task automatic t_clean_suppressed;
        put(3'd3, 2'b00, 14'h0ABC, 1'b0);
        chk("R4 only ch3 strobed", 32'(upd_strobe), 32'b1000);
        chk_ch("R4 ch0 kept", 0, 14'h0123, 2'b00);
        chk_ch("R3 ch3 new", 3, 14'h0ABC, 2'b00);
    endtask

    task automatic t_overwrite;
        put(3'd0, 2'b00, 14'h0111, 1'b1);
        put(3'd0, 2'b00, 14'h0222, 1'b1);
        put(3'd0, 2'b00, 14'h0333, 1'b0);
        chk_ch("R6 last wins", 0, 14'h0333, 2'b00);
        put(3'd2, 2'b00, 14'h0444, 1'b1);
        put(3'd2, 2'b00, 14'h0555, 1'b1);
        put(3'd1, 2'b00, 14'h0789, 1'b0);
        chk_ch("R6 last staged wins", 2, 14'h0555, 2'b00);
    endtask

    task automatic t_invalid_sel;
        put(3'd2, 2'b00, 14'h1234, 1'b1);
        put(3'd5, 2'b00, 14'h3FFF, 1'b0);
        chk("R8 invalid not a commit", 32'(upd_strobe), 32'h0);
        chk_ch("R8 ch2 unchanged", 2, 14'h0555, 2'b00);
        put(3'd4, 2'b00, 14'h3FFF, 1'b1);
        put(3'd1, 2'b00, 14'h0789, 1'b0);
        chk("R8 nothing staged by invalid", 32'(upd_strobe), 32'b0110);
        chk_ch("R8 ch2 staged value intact", 2, 14'h1234, 2'b00);
        chk_ch("R8 ch0 not written", 0, 14'h0333, 2'b00);
    endtask

    task automatic t_broadcast;
        put(3'd7, 2'b00, 14'h2AAA, 1'b0);
        chk("R7 broadcast strobe", 32'(upd_strobe), 32'b1111);
        for (int c = 0; c < NUM_CH; c++) chk_ch("R7 broadcast code", c, 14'h2AAA, 2'b00);
    endtask

    task automatic t_power_down;
        put(3'd1, 2'b11, 14'h0123, 1'b0);
        chk_ch("R10 float keeps code", 1, 14'h2AAA, 2'b11);
        chk("R9 pd strobe", 32'(upd_strobe), 32'b0010);
        put(3'd1, 2'b01, 14'h0000, 1'b1);
        chk_ch("R9 mode held until commit", 1, 14'h2AAA, 2'b11);
        put(3'd0, 2'b10, 14'h0FFF, 1'b0);
        chk_ch("R9 100k on ch0", 0, 14'h2AAA, 2'b10);
        chk_ch("R9 1k on ch1", 1, 14'h2AAA, 2'b01);
        put(3'd0, 2'b00, 14'h2AAA, 1'b1);
        put(3'd1, 2'b00, 14'h0BCD, 1'b0);
        chk_ch("R10 ch0 resumes old code", 0, 14'h2AAA, 2'b00);
        chk_ch("R10 ch1 resumes with new", 1, 14'h0BCD, 2'b00);
    endtask

    task automatic t_idle;
        @(negedge clk);
        wr_valid = 1'b0;
        wr_sel   = 3'd7;
        wr_word  = 16'hC000;
        wr_hold  = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11 idle strobe", 32'(upd_strobe), 32'h0);
        for (int c = 0; c < NUM_CH; c++) chk("R11 idle mode", 32'(pd_mode[2*c +: 2]), 32'h0);
        put(3'd3, 2'b00, 14'h0ABC, 1'b0);
        chk("R11 idle staged nothing", 32'(upd_strobe), 32'b1000);
        chk_ch("R11 ch2 kept", 2, 14'h2AAA, 2'b00);
    endtask

    task automatic t_reset_again;
        put(3'd2, 2'b00, 14'h0777, 1'b1);
        do_reset();
        chk_ch("R1 reset clears ch3", 3, '0, 2'b00);
        put(3'd0, 2'b00, 14'h0000, 1'b0);
        chk("R1 pending cleared", 32'(upd_strobe), 32'b0001);
        chk_ch("R1 ch2 staging cleared", 2, '0, 2'b00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_stage_then_commit();
        t_clean_suppressed();
        t_overwrite();
        t_invalid_sel();
        t_broadcast();
        t_power_down();
        t_idle();
        t_reset_again();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule